// File: doc/BRIEF.md
# Real-Time Clock with Deferred Register Commit

This block keeps time as a fractional counter driven by an external tick-enable pulse and a whole-seconds counter fed by the fractional counter's wrap. Each counter has a compare alarm. When a counting step lands a counter on its alarm value, an interrupt-pending flag is set. A control word gates counting and interrupt delivery. A 32-bit register interface runs on the same clock as the counters. It takes a write in any cycle where select, enable and write are high together. Read data is combinational from the byte address.

A register write does not land at once. Each writable target has its own commit slot. The slot holds the written word for a fixed number of cycles, which models transfer into a slow timekeeping domain, and only then applies it. While a slot is pending, the status word shows a busy flag for that slot and an any-busy summary. A second write to a slot that is still pending is thrown away and sets a sticky error flag. Software clears that flag by writing anything to the status address.

Top module: `slowreg_rtc`

## Requirements
- R1: After reset every readable address returns 0 and `irq_o` is 0.
- R2: Byte addresses: 0x00 fractional counter, 0x04 seconds counter, 0x08 fractional alarm, 0x0C seconds alarm, 0x10 control, 0x14 status, 0x18 interrupt clear. A write to 0x00–0x10 takes effect exactly COMMIT_CYCLES (default 4) cycles after the accepting clock edge. A read before that point returns the old value.
- R3: Status bit 3 is high while any commit is pending. Status bits 4..10 are the pending flags, in this order: fractional counter, seconds counter, fractional alarm, seconds alarm, control, fractional clear, seconds clear. Each flag is high for exactly COMMIT_CYCLES cycles after its write is accepted.
- R4: A write to a slot whose pending flag is high is discarded: the earlier value still commits. The write also sets status bit 2, which stays set.
- R5: Any write to 0x14 clears status bit 2 in the next cycle. Such a write starts no commit and changes no other state.
- R6: The fractional counter advances by one on each cycle with `tick_i` high while control bit 0 is 1. It holds its value while control bit 0 is 0.
- R7: The fractional counter wraps from SUB_MOD-1 (default 32767) to 0. That wrap increments the seconds counter only when control bit 1 is 1. Otherwise the seconds counter holds.
- R8: A counting step that brings the fractional counter to its alarm value sets status bit 0. A seconds increment that reaches the seconds alarm sets status bit 1. Committed writes never set these bits.
- R9: `irq_o` is high exactly when (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3).
- R10: A write to 0x18 with bit 0 = 1 (or bit 1 = 1) clears status bit 0 (or bit 1) when that clear commits. Bits written as 0 start nothing. Reads of 0x18 return 0.
- R11: Control bits above 3, status bits above 10, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counting |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Fractional-count enable pulse |
| sel_i | input | 1 | Register select |
| en_i | input | 1 | Access enable |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an overlapping write: a second write must land on the same slot while its first commit is still pending. The bench issues two writes to the seconds alarm on consecutive cycles, then checks that the first value survives the commit and the error bit stays set. Seconds-alarm interrupts would need tens of thousands of ticks from reset. Instead, the bench commits a fractional value just below the wrap and a seconds value just below the alarm, so a single tick produces both the carry and the alarm hit.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
   localparam int NSLOT = 7;
   // slot order is the status bit order (bits 4..10)
   typedef enum logic [2:0] {
      SL_SUBCNT = 3'd0,
      SL_SECCNT = 3'd1,
      SL_SUBALM = 3'd2,
      SL_SECALM = 3'd3,
      SL_CTRL   = 3'd4,
      SL_CLRSUB = 3'd5,
      SL_CLRSEC = 3'd6
   } slot_e;
   // word index of each address
   localparam logic [2:0] WI_STATUS = 3'd5;
   localparam logic [2:0] WI_CLEAR  = 3'd6;
endpackage

// File: rtl/srtc_commit_slot.sv
module srtc_commit_slot #(
   parameter int DW            = 32,
   parameter int COMMIT_CYCLES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic          overlap_o,
   output logic          commit_o,
   output logic [DW-1:0] data_o
);
   localparam int CW = $clog2(COMMIT_CYCLES + 1);

   if (COMMIT_CYCLES < 1) begin : g_bad_delay
      $error("COMMIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign overlap_o = start_i && busy_o;
   assign commit_o  = busy_o && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
         data_o <= '0;
      end else if (start_i && !busy_o) begin
         busy_o <= 1'b1;
         cnt_q  <= CW'(COMMIT_CYCLES);
         data_o <= data_i;
      end else if (busy_o) begin
         if (cnt_q == CW'(1)) busy_o <= 1'b0;
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assert_busy_from_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
   assert_commit_ends_busy_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !busy_o);
endmodule

// File: rtl/srtc_timebase.sv
module srtc_timebase #(
   parameter int SUB_MOD = 32768,
   parameter int SEC_W   = 32,
   localparam int SUB_W  = $clog2(SUB_MOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_sub_i,
   input  logic             en_sec_i,
   input  logic             ld_sub_i,
   input  logic [SUB_W-1:0] ld_sub_val_i,
   input  logic             ld_sec_i,
   input  logic [SEC_W-1:0] ld_sec_val_i,
   input  logic [SUB_W-1:0] alm_sub_i,
   input  logic [SEC_W-1:0] alm_sec_i,
   output logic [SUB_W-1:0] sub_o,
   output logic [SEC_W-1:0] sec_o,
   output logic             sub_hit_o,
   output logic             sec_hit_o
);
   if (SUB_MOD < 2 || (SUB_MOD & (SUB_MOD - 1)) != 0) begin : g_bad_mod
      $error("SUB_MOD must be a power of two of at least 2");
   end
   if (SEC_W < 1 || SEC_W > 32) begin : g_bad_sec
      $error("SEC_W must lie in 1..32");
   end

   logic             sub_step, wrap, sec_step;
   logic [SUB_W-1:0] sub_nxt;
   logic [SEC_W-1:0] sec_nxt;

   assign sub_step  = tick_i && en_sub_i && !ld_sub_i;
   assign wrap      = sub_step && (sub_o == SUB_W'(SUB_MOD - 1));
   assign sub_nxt   = wrap ? '0 : sub_o + SUB_W'(1);
   assign sec_step  = wrap && en_sec_i && !ld_sec_i;
   assign sec_nxt   = sec_o + SEC_W'(1);
   assign sub_hit_o = sub_step && (sub_nxt == alm_sub_i);
   assign sec_hit_o = sec_step && (sec_nxt == alm_sec_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_o <= '0;
         sec_o <= '0;
      end else begin
         if (ld_sub_i)      sub_o <= ld_sub_val_i;
         else if (sub_step) sub_o <= sub_nxt;
         if (ld_sec_i)      sec_o <= ld_sec_val_i;
         else if (sec_step) sec_o <= sec_nxt;
      end
   end

   assert_sub_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_sub_i && !ld_sub_i) |=> $stable(sub_o));
   assert_sec_holds_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_sec_i && !ld_sec_i) |=> $stable(sec_o));
   assert_carry_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && en_sec_i && !ld_sec_i) |=> (sec_o == $past(sec_o) + SEC_W'(1)));
endmodule

// File: rtl/srtc_irq.sv
module srtc_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] hit_i,
   input  logic [1:0] clr_i,
   input  logic [1:0] ie_i,
   output logic [1:0] pend_o,
   output logic       irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~clr_i) | hit_i;
   end

   assign irq_o = |(pend_o & ie_i);

   assert_hit_sets_pend_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      hit_i[0] |=> pend_o[0]);
   assert_clear_drops_pend_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[1] && !hit_i[1]) |=> !pend_o[1]);
endmodule

// File: rtl/slowreg_rtc.sv
module slowreg_rtc
   import srtc_pkg::*;
#(
   parameter int ADDR_W        = 5,
   parameter int SUB_MOD       = 32768,
   parameter int SEC_W         = 32,
   parameter int COMMIT_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sel_i,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);
   localparam int SUB_W = $clog2(SUB_MOD);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic                  wr_acc, stat_wr, in_map;
   logic [2:0]            widx;
   logic [NSLOT-1:0]      start, busy, ovl, commit;
   logic [31:0]           sdata [NSLOT];
   logic [SUB_W-1:0]      alm_sub_q, sub_cnt;
   logic [SEC_W-1:0]      alm_sec_q, sec_cnt;
   logic [3:0]            ctrl_q;
   logic                  err_q;
   logic                  sub_hit, sec_hit;
   logic [1:0]            pend;

   assign wr_acc  = sel_i && en_i && wr_i;
   assign widx    = addr_i[4:2];
   assign in_map  = (addr_i[1:0] == 2'b00) && (ADDR_W == 5 || addr_i >= 0) &&
                    (addr_i >> 5) == '0;
   assign stat_wr = wr_acc && in_map && (widx == WI_STATUS);

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i < 5) begin : g_reg
         assign start[i] = wr_acc && in_map && (widx == 3'(i));
      end else begin : g_clr
         assign start[i] = wr_acc && in_map && (widx == WI_CLEAR) && wdata_i[i-5];
      end
      srtc_commit_slot #(.DW(32), .COMMIT_CYCLES(COMMIT_CYCLES)) u_slot (
         .clk(clk), .rst_n(rst_n), .start_i(start[i]), .data_i(wdata_i),
         .busy_o(busy[i]), .overlap_o(ovl[i]), .commit_o(commit[i]), .data_o(sdata[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alm_sub_q <= '0;
         alm_sec_q <= '0;
         ctrl_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         if (commit[SL_SUBALM]) alm_sub_q <= sdata[SL_SUBALM][SUB_W-1:0];
         if (commit[SL_SECALM]) alm_sec_q <= sdata[SL_SECALM][SEC_W-1:0];
         if (commit[SL_CTRL])   ctrl_q    <= sdata[SL_CTRL][3:0];
         if (stat_wr)           err_q     <= 1'b0;
         else if (|ovl)         err_q     <= 1'b1;
      end
   end

   srtc_timebase #(.SUB_MOD(SUB_MOD), .SEC_W(SEC_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .en_sub_i(ctrl_q[0]), .en_sec_i(ctrl_q[1]),
      .ld_sub_i(commit[SL_SUBCNT]), .ld_sub_val_i(sdata[SL_SUBCNT][SUB_W-1:0]),
      .ld_sec_i(commit[SL_SECCNT]), .ld_sec_val_i(sdata[SL_SECCNT][SEC_W-1:0]),
      .alm_sub_i(alm_sub_q), .alm_sec_i(alm_sec_q),
      .sub_o(sub_cnt), .sec_o(sec_cnt), .sub_hit_o(sub_hit), .sec_hit_o(sec_hit));

   srtc_irq u_irq (
      .clk(clk), .rst_n(rst_n), .hit_i({sec_hit, sub_hit}),
      .clr_i({commit[SL_CLRSEC], commit[SL_CLRSUB]}),
      .ie_i(ctrl_q[3:2]), .pend_o(pend), .irq_o(irq_o));

   always_comb begin
      rdata_o = '0;
      if (in_map) begin
         unique case (widx)
            3'd0:      rdata_o = 32'(sub_cnt);
            3'd1:      rdata_o = 32'(sec_cnt);
            3'd2:      rdata_o = 32'(alm_sub_q);
            3'd3:      rdata_o = 32'(alm_sec_q);
            3'd4:      rdata_o = 32'(ctrl_q);
            WI_STATUS: rdata_o = {21'd0, busy, |busy, err_q, pend};
            default:   rdata_o = '0;
         endcase
      end
   end

   assert_overlap_sets_err_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (|ovl && !stat_wr) |=> err_q);
   assert_status_write_clears_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> !err_q);
   assert_irq_needs_pend_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|pend));
endmodule

// File: tb/sim_slowreg_rtc.sv
module sim_slowreg_rtc;
   localparam int C = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        sel_i = 1'b0, en_i = 1'b0, wr_i = 1'b0;
   logic [4:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o;
   int          n_chk = 0, n_err = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   slowreg_rtc u0 (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i),
      .en_i(en_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_o(irq_o));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the negedge after the accepting edge
   task automatic wr(logic [4:0] a, logic [31:0] d);
      sel_i = 1'b1; en_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      sel_i = 1'b0; en_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      addr_i = a;
      #1 d = rdata_o;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), d);
         chk("R1 reset read", d, 32'h0);
      end
      chk("R1 reset irq", 32'(irq_o), 32'h0);
   endtask

   task automatic t_commit_delay;
      logic [31:0] d;
      wr(5'h08, 32'd5);
      rd(5'h14, d);
      chk("R3 busy fractional alarm", d, 32'h48);
      wait_n(C - 1);
      rd(5'h08, d);
      chk("R2 old value before commit", d, 32'h0);
      rd(5'h14, d);
      chk("R3 busy held full interval", d, 32'h48);
      wait_n(1);
      rd(5'h08, d);
      chk("R2 value after commit", d, 32'd5);
      rd(5'h14, d);
      chk("R3 busy drops after commit", d, 32'h0);
   endtask

   task automatic t_overlap;
      logic [31:0] d;
      wr(5'h0C, 32'd7);
      wr(5'h0C, 32'd8);
      rd(5'h14, d);
      chk("R4 error and seconds alarm busy", d, 32'h8C);
      wait_n(C);
      rd(5'h0C, d);
      chk("R4 first value kept", d, 32'd7);
      rd(5'h14, d);
      chk("R4 error sticky", d, 32'h4);
      wr(5'h14, 32'h0);
      rd(5'h14, d);
      chk("R5 status write clears error", d, 32'h0);
      rd(5'h0C, d);
      chk("R5 no other effect", d, 32'd7);
   endtask

   task automatic t_count_alarm;
      logic [31:0] d;
      wr(5'h10, 32'hFFFF_FFF5);      // enable fractional count + fractional irq
      wait_n(C);
      rd(5'h10, d);
      chk("R11 control upper bits zero", d, 32'h5);
      ticks(4);
      rd(5'h00, d);
      chk("R6 counts ticks", d, 32'd4);
      rd(5'h14, d);
      chk("R8 no hit yet", d, 32'h0);
      chk("R9 irq low", 32'(irq_o), 32'h0);
      ticks(1);
      rd(5'h14, d);
      chk("R8 alarm sets bit 0", d, 32'h1);
      chk("R9 irq high", 32'(irq_o), 32'h1);
      wr(5'h18, 32'h0);
      rd(5'h14, d);
      chk("R10 zero write starts nothing", d, 32'h1);
      rd(5'h18, d);
      chk("R10 clear reads zero", d, 32'h0);
      wr(5'h18, 32'h1);
      rd(5'h14, d);
      chk("R3 clear busy bit 9", d, 32'h209);
      wait_n(C);
      rd(5'h14, d);
      chk("R10 pending cleared", d, 32'h0);
      chk("R9 irq low after clear", 32'(irq_o), 32'h0);
      wr(5'h10, 32'h4);             // counting off, irq enable kept
      wait_n(C);
      ticks(3);
      rd(5'h00, d);
      chk("R6 holds when disabled", d, 32'd5);
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      wr(5'h00, 32'd32766);
      wr(5'h04, 32'd9);
      wr(5'h10, 32'h1);             // fractional only
      wait_n(C);
      ticks(2);
      rd(5'h00, d);
      chk("R7 wrap to zero", d, 32'd0);
      rd(5'h04, d);
      chk("R7 seconds hold when disabled", d, 32'd9);
      wr(5'h00, 32'd32767);
      wr(5'h04, 32'd2);
      wr(5'h0C, 32'd3);
      wr(5'h10, 32'hB);             // both counts, seconds irq
      wait_n(C);
      ticks(1);
      rd(5'h04, d);
      chk("R7 carry increments seconds", d, 32'd3);
      rd(5'h14, d);
      chk("R8 seconds alarm sets bit 1", d, 32'h2);
      chk("R9 irq from seconds", 32'(irq_o), 32'h1);
      wr(5'h10, 32'h3);
      wait_n(C);
      chk("R9 irq masked by enable", 32'(irq_o), 32'h0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_commit_delay();
      t_overlap();
      t_count_alarm();
      t_wrap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule